// File: doc/BRIEF.md
# Serial Register Slave with Gated Readback

This block is the configuration port of a video encoder. It is a two-wire serial slave that gives an external master access to a 256-entry register file of 8-bit words. The block watches the serial clock and data lines. A system clock many times faster than the serial clock samples both lines. The slave finds start and stop conditions and answers to one 7-bit device address, whose lowest bit is set by a strap pin. It keeps an 8-bit register pointer, which the first byte after a write address loads. Write transactions store any number of data bytes at consecutive addresses. Read transactions return consecutive registers for as long as the master acknowledges.

Register data only leaves the block once software has enabled readback. Software does this by setting a bit in a control register. Until then the slave still acknowledges its read address, but it leaves the data line released, so the master reads all ones. The lowest seven addresses form a fixed identification window. Word 0 holds a part-type code and a version number. Writes to that window are acknowledged and then dropped. The block only ever pulls the data line low; a high level is produced by releasing the line.

Top module: `sreg_slave`

## Requirements
- R1: After reset, and one system clock after any start or stop condition, the data drive output is off. A start condition is the data line falling while the clock line is high. A stop condition is the data line rising while the clock line is high.
- R2: The slave acknowledges the address byte 0x88 (write) or 0x89 (read) when the strap is low, and 0x8A or 0x8B when the strap is high. The 7-bit address sits in bits [7:1] and the read flag in bit 0. On any other address the slave does not acknowledge, and it drives nothing until the next start.
- R3: In a write transaction, the first byte after the address loads the pointer. Each further byte is stored at the pointer, which then advances by one. Every byte is acknowledged.
- R4: Read data goes out most significant bit first. After each byte the pointer advances by one, and a master acknowledge makes the slave send the register at the new pointer. The pointer wraps from 0xFF to 0x00.
- R5: A master non-acknowledge ends the read, and the slave leaves the line released until the next start or stop.
- R6: Readback is enabled while bit 6 of register 0x6C is 1. Writing 0x46 there sets the bit, and writing 0x00 clears it. While the bit is 0, read addresses are still acknowledged, but every data bit is left released, so each byte reads as 0xFF.
- R7: Addresses 0x00 to 0x06 are read-only, and writes to them are acknowledged but have no effect. Register 0x00 reads {part type[2:0], version[4:0]}, which is 0x43 with the default parameters. Registers 0x01 to 0x06 read 0x00.
- R8: A repeated start in the middle of a transaction restarts address matching. The pointer keeps the value that was loaded before it.
- R9: The drive output changes only while the serial clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as it appears on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| addr_sel_i | input | 1 | Strap that sets the low bit of the device address |

## Verification
Most internal faults show up on the data line within one byte time. A wrong bit counter moves the acknowledge slot, so the very next acknowledge the bench looks for goes missing. A pointer that is wrong or never advances returns the wrong word on the first sequential read, or on the first wrapped read. A read-only window that can be written, or a read-enable bit that is stuck, appears on the next readback of that address as a mismatch against the model's expected byte. The checker also catches the drive changing while the serial clock is high, or drive appearing while the slave is unaddressed or gated, in the cycle it happens.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_ACKDEV,
    ST_SUBADR,
    ST_ACKSUB,
    ST_WRBYTE,
    ST_ACKWR,
    ST_RDBYTE,
    ST_RDACK,
    ST_IGNORE
  } ser_state_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  // idle bus level is high: reset to ones so no false edge appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
#(
  parameter int         RO_LAST = 6,
  parameter int         EN_ADDR = 'h6C,
  parameter int         EN_BIT  = 6,
  parameter logic [2:0] PART_ID = 3'b010,
  parameter logic [4:0] VERSION = 5'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_allow
);
  logic [BYTE_W-1:0] word [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (i == 0) begin : g_id
      assign word[i] = {PART_ID, VERSION};
    end else if (i <= RO_LAST) begin : g_stat
      assign word[i] = '0;
    end else begin : g_rw
      logic [BYTE_W-1:0] cell_q;
      logic              cell_we;
      assign cell_we = wr_en && (wr_addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cell_q <= '0;
        else if (cell_we) cell_q <= wr_data;
      end
      assign word[i] = cell_q;
    end
  end

  assign rd_data  = word[rd_addr];
  assign rd_allow = word[EN_ADDR][EN_BIT];
endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_BASE = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              rd_allow,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output ser_state_t        state
);
  ser_state_t        state_q, state_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d, rw_q, rw_d, ack_q, ack_d;
  logic              rx_bit, rx_done;
  logic [6:0]        dev_addr;

  assign dev_addr = {DEV_BASE[6:1], addr_sel};
  assign rx_bit   = scl_rise && (bit_q != 4'd8);
  assign rx_done  = scl_fall && (bit_q == 4'd8);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    ack_d   = ack_q;
    wr_en   = 1'b0;
    if (start_evt) begin
      state_d = ST_DEVADR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_evt) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEVADR, ST_SUBADR, ST_WRBYTE: begin
          if (rx_bit) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (rx_done) begin
            bit_d = '0;
            if (state_q == ST_DEVADR) begin
              if (sh_q[7:1] == dev_addr) begin
                state_d = ST_ACKDEV;
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_SUBADR) begin
              ptr_d   = sh_q;
              oe_d    = 1'b1;
              state_d = ST_ACKSUB;
            end else begin
              wr_en   = 1'b1;
              ptr_d   = ptr_q + 1'b1;
              oe_d    = 1'b1;
              state_d = ST_ACKWR;
            end
          end
        end
        ST_ACKDEV: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              sh_d    = rd_data;
              oe_d    = rd_allow & ~rd_data[7];
              state_d = ST_RDBYTE;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_SUBADR;
            end
          end
        end
        ST_ACKSUB, ST_ACKWR: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            bit_d   = '0;
            state_d = ST_WRBYTE;
          end
        end
        ST_RDBYTE: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_d    = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RDACK;
            end else begin
              bit_d = bit_q + 4'd1;
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = rd_allow & ~sh_q[6];
            end
          end
        end
        ST_RDACK: begin
          if (scl_rise) begin
            ack_d = ~sda_lvl;
          end else if (scl_fall) begin
            bit_d = '0;
            if (ack_q) begin
              sh_d    = rd_data;
              oe_d    = rd_allow & ~rd_data[7];
              state_d = ST_RDBYTE;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      ack_q   <= ack_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;
  assign state   = state_q;
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
  import sreg_pkg::*;
#(
  parameter logic [6:0] DEV_BASE = 7'h44,
  parameter int         RO_LAST  = 6,
  parameter int         EN_ADDR  = 'h6C,
  parameter int         EN_BIT   = 6,
  parameter logic [2:0] PART_ID  = 3'b010,
  parameter logic [4:0] VERSION  = 5'h03
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic addr_sel_i
);
  logic [1:0]        rst_q;
  logic              rst_n_s;
  logic [1:0]        line_lvl, line_rise, line_fall;
  logic              start_evt, stop_evt;
  logic [ADDR_W-1:0] ptr;
  logic              wr_en, rd_allow;
  logic [BYTE_W-1:0] wr_data, rd_data;
  ser_state_t        state_w;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  // bit 0: clock line, bit 1: data line
  sreg_sync #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .din  ({sda_i, scl_i}),
    .lvl  (line_lvl),
    .rise (line_rise),
    .fall (line_fall)
  );

  assign start_evt = line_lvl[0] & line_fall[1];
  assign stop_evt  = line_lvl[0] & line_rise[1];

  sreg_ctrl #(.DEV_BASE(DEV_BASE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .scl_rise (line_rise[0]),
    .scl_fall (line_fall[0]),
    .sda_lvl  (line_lvl[1]),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .addr_sel (addr_sel_i),
    .rd_data  (rd_data),
    .rd_allow (rd_allow),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe_o),
    .state    (state_w)
  );

  sreg_file #(
    .RO_LAST(RO_LAST),
    .EN_ADDR(EN_ADDR),
    .EN_BIT (EN_BIT),
    .PART_ID(PART_ID),
    .VERSION(VERSION)
  ) u_file (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data),
    .rd_allow(rd_allow)
  );
endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk
  import sreg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       wr_en,
  input logic       rd_allow,
  input ser_state_t state
);
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);

  a_r6_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDBYTE && !rd_allow) |-> !sda_oe);

  a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);
endmodule

bind sreg_slave sreg_slave_chk chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe_o),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .wr_en    (wr_en),
  .rd_allow (rd_allow),
  .state    (state_w)
);

// File: tb/sreg_slave_test.sv
module sreg_slave_test;
  localparam int Q = 10;

  logic clk, rst_n, scl_m, sda_m, addr_sel, sda_oe;
  wire  line = sda_m & ~sda_oe;
  int   n_chk = 0, n_err = 0, r9_viol = 0;
  logic [7:0] model [256];
  logic prev_oe;

  sreg_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (line),
    .sda_oe_o  (sda_oe),
    .addr_sel_i(addr_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R9 monitor: drive may only move while the clock line is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) r9_viol++;
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1; wq(); scl_m = 1; wq(); b = line; wq(); scl_m = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~mack);
  endtask

  function automatic logic [7:0] expect_rd(input int a);
    return model[8'h6C][6] ? model[a] : 8'hFF;
  endfunction

  // write transaction: sub-address then data bytes; every ack checked (R3)
  task automatic wr_txn(input logic [7:0] dev, input int sub, input logic [7:0] d [$]);
    logic ack;
    int p = sub;
    bus_start();
    send_byte(dev, ack);
    check(ack, "R2 write address ack", ack, 1);
    send_byte(sub[7:0], ack);
    check(ack, "R3 sub-address ack", ack, 1);
    foreach (d[k]) begin
      send_byte(d[k], ack);
      check(ack, (p <= 6) ? "R7 read-only write ack" : "R3 data ack", ack, 1);
      if (p > 6) model[p] = d[k];
      p = (p + 1) % 256;
    end
    bus_stop();
  endtask

  // set pointer, then read n bytes and compare with the model (R4)
  task automatic rd_txn(input logic [7:0] dev, input int sub, input int n, input string req);
    logic ack;
    logic [7:0] v;
    logic [7:0] none [$];
    int p = sub;
    wr_txn(dev & 8'hFE, sub, none);
    bus_start();
    send_byte(dev | 8'h01, ack);
    check(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(v, k != n - 1);
      check(v == expect_rd(p), req, v, expect_rd(p));
      p = (p + 1) % 256;
    end
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[0] = 8'h43;
    rst_n = 0; scl_m = 1; sda_m = 1; addr_sel = 0; prev_oe = 0;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R2: wrong address is not acked, and traffic after it is ignored
    bus_start();
    send_byte(8'h8A, ack);
    check(!ack, "R2 mismatch nack", ack, 0);
    send_byte(8'h55, ack);
    check(!ack, "R2 ignored until start", ack, 0);
    bus_stop();
    check(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

    // R6: readback gated before enable
    rd_txn(8'h88, 8'h00, 1, "R6 gated read all ones");
    wr_txn(8'h88, 8'h6C, '{8'h46});
    rd_txn(8'h88, 8'h6C, 1, "R6 enable readback");

    // R7: identity word and read-only window
    rd_txn(8'h88, 8'h00, 1, "R7 identity word");
    wr_txn(8'h88, 8'h03, '{8'h5A});
    rd_txn(8'h88, 8'h03, 1, "R7 read-only unchanged");

    // R3/R4: burst write and sequential read
    wr_txn(8'h88, 8'h20, '{8'h11, 8'h22, 8'h33});
    rd_txn(8'h88, 8'h20, 3, "R4 sequential read");

    // R4: wrap from 0xFF to 0x00
    wr_txn(8'h88, 8'hFF, '{8'hA5});
    rd_txn(8'h88, 8'hFF, 2, "R4 pointer wrap");

    // R5: after nack, further clocks read released line
    rd_txn(8'h88, 8'h20, 1, "R5 byte before nack");
    bus_start();
    send_byte(8'h89, ack);
    recv_byte(v, 1'b0);
    check(v == 8'h22, "R5 read then nack", v, 8'h22);
    recv_byte(v, 1'b0);
    check(v == 8'hFF, "R5 released after nack", v, 8'hFF);
    bus_stop();

    // R8: repeated start switches from write to read
    bus_start();
    send_byte(8'h88, ack);
    send_byte(8'h22, ack);
    check(ack, "R8 sub-address before restart", ack, 1);
    bus_rstart();
    check(sda_oe == 1'b0, "R1 released after start", sda_oe, 0);
    send_byte(8'h89, ack);
    check(ack, "R8 read address after restart", ack, 1);
    recv_byte(v, 1'b0);
    check(v == 8'h33, "R8 data after restart", v, 8'h33);
    bus_stop();

    // R2: strap high selects 0x8A
    addr_sel = 1;
    repeat (5) @(negedge clk);
    bus_start();
    send_byte(8'h88, ack);
    check(!ack, "R2 old address with strap high", ack, 0);
    bus_stop();
    wr_txn(8'h8A, 8'h30, '{8'h77});
    rd_txn(8'h8A, 8'h30, 1, "R2 strap high readback");

    // R6: clearing the enable gates reads again
    wr_txn(8'h8A, 8'h6C, '{8'h00});
    rd_txn(8'h8A, 8'h30, 1, "R6 disabled again");

    check(r9_viol == 0, "R9 drive moved with clock high", r9_viol, 0);
    finish_run();
  end
endmodule